// File: doc/BRIEF.md
# USB OUT Endpoint Buffer Controller

This block is the receive side of one device endpoint. A serial interface engine hands it events that are already decoded: an OUT token strobe, a stream of data bytes, and an end-of-packet strobe. The end-of-packet strobe carries the data PID parity (DATA0 or DATA1) and a flag for a CRC or bit-stuff error. The block decides which handshake to return and whether to keep the packet. Kept packets go into a store with one or two packet slots.

Firmware drains the store through a byte-wide read port. It sees a ready flag, the byte count of the current packet, several status flags and one level interrupt. It steers the endpoint through single-cycle command strobes and static configuration levels. Bulk/interrupt mode and isochronous mode follow different rules for stalling, errors and overflow. Double buffering lets a second packet arrive while the first is still being read. An auto-release option frees a slot by itself once a packet of the configured maximum size has been read to its end.

Top module: `usb_out_ep`

## Requirements
- R1: After reset, pkt_rdy, fifo_full, data_err, overrun, sent_stall, irq and hs_strobe are all 0, and the first packet accepted in bulk mode must be DATA0 (rx_pid_odd=0).
- R2: In bulk mode (cfg_iso=0), a packet with no error, a free slot and the expected PID parity gets hs_strobe=1 with hs_code=2'b01 (ACK) in the cycle after rx_eop. The packet is stored, pkt_rdy rises, rx_count equals its byte count, rd_data returns its bytes in order, and the expected parity flips.
- R3: In bulk mode, an error-free packet with a free slot whose PID parity differs from the expected one is answered with ACK but is not stored, and the expected parity is left unchanged.
- R4: A pulse on fw_clr_toggle sets the expected parity back to DATA0.
- R5: In bulk mode, a packet whose end-of-packet has rx_err=1 gets no handshake (hs_strobe stays 0) and is not stored.
- R6: In bulk mode, an error-free packet that arrives while the store is full gets hs_code=2'b10 (NAK). It is dropped and the expected parity is unchanged.
- R7: With cfg_stall=1 in bulk mode, an OUT token is answered with hs_code=2'b11 (STALL) in the next cycle, and the packet data that follows is ignored. Each such reply sets sent_stall, which holds until fw_clr_sent_stall. In isochronous mode, cfg_stall has no effect.
- R8: In isochronous mode, no handshake is ever issued, and a packet is stored even when rx_err=1. data_err equals the stored error flag of the current packet while pkt_rdy=1 in isochronous mode, and is 0 otherwise.
- R9: In isochronous mode, a packet that arrives while the store is full is dropped and sets overrun, which holds until fw_clr_overrun.
- R10: fifo_full is 1 exactly when one packet is held with cfg_dbl=0, or two packets are held with cfg_dbl=1.
- R11: A pulse on fw_pkt_done releases the current packet. The next held packet, if there is one, becomes current with its own rx_count and data.
- R12: Each pulse on fw_flush discards only the oldest held packet, so two pulses are needed to empty two held packets.
- R13: With cfg_autoclr=1, reading the last byte of a packet whose length equals cfg_max releases that packet with no command. Shorter packets stay held.
- R14: irq equals irq_en AND (pkt_rdy OR sent_stall).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_iso | input | 1 | 1 = isochronous, 0 = bulk/interrupt |
| cfg_dbl | input | 1 | Enable two packet slots |
| cfg_autoclr | input | 1 | Auto-release after reading a maximum-size packet |
| cfg_stall | input | 1 | Request STALL replies (bulk only) |
| cfg_max | input | CNT_W | Maximum packet size in bytes |
| irq_en | input | 1 | Interrupt enable |
| tok_out | input | 1 | OUT token strobe |
| rx_vld | input | 1 | Received data byte strobe |
| rx_byte | input | 8 | Received data byte |
| rx_eop | input | 1 | End-of-packet strobe |
| rx_pid_odd | input | 1 | PID parity at end-of-packet (1 = DATA1) |
| rx_err | input | 1 | CRC or bit-stuff error at end-of-packet |
| hs_strobe | output | 1 | Handshake request |
| hs_code | output | 2 | 01 ACK, 10 NAK, 11 STALL |
| fw_clr_toggle | input | 1 | Reset expected parity to DATA0 |
| fw_flush | input | 1 | Discard the oldest held packet |
| fw_pkt_done | input | 1 | Release the current packet |
| fw_clr_sent_stall | input | 1 | Clear sent_stall |
| fw_clr_overrun | input | 1 | Clear overrun |
| rd_en | input | 1 | Advance the read pointer |
| rd_data | output | 8 | Byte at the read pointer |
| pkt_rdy | output | 1 | A packet is held |
| fifo_full | output | 1 | No slot is free |
| data_err | output | 1 | Current isochronous packet was received with an error |
| overrun | output | 1 | An isochronous packet was lost |
| sent_stall | output | 1 | A STALL was sent |
| rx_count | output | CNT_W | Byte count of the current packet |
| irq | output | 1 | Endpoint interrupt |

## Verification
A wrong expected parity appears at once on the next bulk packet: a good packet is acked but never raises pkt_rdy, or a retransmission is stored as a new packet. A slot counter or slot pointer that drifts appears within one firmware read: rx_count, rd_data or fifo_full disagree with the packets sent, or a flush removes the wrong packet. The bench drives random bulk traffic in single- and double-buffered modes against a bench model of the slot ring and the parity. It also runs directed cases for stall, isochronous error and overflow, flushing, and auto-release, and compares every handshake and every byte read.

// File: rtl/usb_oep_pkg.sv
`timescale 1ns/1ps
package usb_oep_pkg;
   typedef enum logic [1:0] {
      HS_NONE  = 2'b00,
      HS_ACK   = 2'b01,
      HS_NAK   = 2'b10,
      HS_STALL = 2'b11
   } hs_e;
endpackage

// File: rtl/oep_rx_ctrl.sv
`timescale 1ns/1ps
module oep_rx_ctrl
   import usb_oep_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       iso,
   input  logic       stall_req,
   input  logic       clr_tog,
   input  logic       tok,
   input  logic       vld,
   input  logic       eop,
   input  logic       pid_odd,
   input  logic       rx_err,
   input  logic       full,
   output logic       open,
   output logic       wr_en,
   output logic       commit,
   output logic       stall_pulse,
   output logic       ovr_pulse,
   output logic       hs_strobe,
   output hs_e        hs_code
);
   logic active, room, tog;

   assign stall_pulse = tok && !iso && stall_req;
   assign open        = tok && !stall_pulse;
   assign wr_en       = vld && active && room;
   assign commit      = eop && active && room && (iso || (!rx_err && (pid_odd == tog)));
   assign ovr_pulse   = eop && active && iso && !room;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         room      <= 1'b0;
         hs_strobe <= 1'b0;
         hs_code   <= HS_NONE;
      end else begin
         hs_strobe <= 1'b0;
         if (stall_pulse) begin
            hs_strobe <= 1'b1;
            hs_code   <= HS_STALL;
            active    <= 1'b0;
         end else if (tok) begin
            active <= 1'b1;
            room   <= !full;
         end else if (eop && active) begin
            active <= 1'b0;
            if (!iso && !rx_err) begin
               hs_strobe <= 1'b1;
               hs_code   <= room ? HS_ACK : HS_NAK;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                tog <= 1'b0;
      else if (clr_tog)          tog <= 1'b0;
      else if (commit && !iso)   tog <= ~tog;
   end

   // R7
   stall_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tok && !iso && stall_req) |=> (hs_strobe && hs_code == HS_STALL));
   // R8
   iso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eop && iso && !tok) |=> !hs_strobe);
   // R5
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eop && !iso && rx_err && !tok) |=> !hs_strobe);
endmodule

// File: rtl/oep_pkt_store.sv
`timescale 1ns/1ps
module oep_pkt_store #(
   parameter  int MAX_PKT     = 64,
   parameter  bit DBL_CAPABLE = 1'b1,
   localparam int PTR_W       = $clog2(MAX_PKT),
   localparam int CNT_W       = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dbl,
   input  logic             open,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic             commit,
   input  logic             commit_err,
   input  logic             pop,
   input  logic             rd_en,
   output logic             full,
   output logic             any,
   output logic [7:0]       rd_data,
   output logic [CNT_W-1:0] cur_len,
   output logic             cur_err,
   output logic             last_rd
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_PKT);

   logic [7:0]       mem [2*MAX_PKT];
   logic [CNT_W-1:0] wcnt, rptr;
   logic [CNT_W-1:0] len_q [2];
   logic             err_q [2];
   logic             wsel, rsel, cap_two, do_pop;
   logic [1:0]       held;

   if (DBL_CAPABLE) begin : g_dbl
      assign cap_two = dbl;
   end else begin : g_sgl
      logic dbl_unused;
      assign dbl_unused = dbl;
      assign cap_two    = 1'b0;
   end

   assign any     = (held != 2'd0);
   assign full    = cap_two ? (held == 2'd2) : any;
   assign do_pop  = pop && any;
   assign cur_len = len_q[rsel];
   assign cur_err = err_q[rsel];
   assign rd_data = mem[{rsel, rptr[PTR_W-1:0]}];
   assign last_rd = rd_en && any && ((rptr + CNT_W'(1)) == cur_len);

   always_ff @(posedge clk) begin
      if (wr_en && wcnt < LIMIT) mem[{wsel, wcnt[PTR_W-1:0]}] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt     <= '0;
         rptr     <= '0;
         wsel     <= 1'b0;
         rsel     <= 1'b0;
         held     <= 2'd0;
         len_q[0] <= '0;
         len_q[1] <= '0;
         err_q[0] <= 1'b0;
         err_q[1] <= 1'b0;
      end else begin
         if (open)                            wcnt <= '0;
         else if (wr_en && wcnt < LIMIT)      wcnt <= wcnt + CNT_W'(1);
         if (commit) begin
            len_q[wsel] <= wcnt;
            err_q[wsel] <= commit_err;
            wsel        <= ~wsel;
         end
         if (do_pop) begin
            rsel <= ~rsel;
            rptr <= '0;
         end else if (rd_en && any && rptr < cur_len) begin
            rptr <= rptr + CNT_W'(1);
         end
         case ({commit, do_pop})
            2'b10:   held <= held + 2'd1;
            2'b01:   held <= held - 2'd1;
            default: held <= held;
         endcase
      end
   end

   // R10
   held_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      held <= 2'd2);
   // R6
   commit_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !full);
endmodule

// File: rtl/usb_out_ep.sv
`timescale 1ns/1ps
module usb_out_ep
   import usb_oep_pkg::*;
#(
   parameter  int MAX_PKT     = 64,
   parameter  bit DBL_CAPABLE = 1'b1,
   localparam int CNT_W       = $clog2(MAX_PKT) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_iso,
   input  logic             cfg_dbl,
   input  logic             cfg_autoclr,
   input  logic             cfg_stall,
   input  logic [CNT_W-1:0] cfg_max,
   input  logic             irq_en,
   input  logic             tok_out,
   input  logic             rx_vld,
   input  logic [7:0]       rx_byte,
   input  logic             rx_eop,
   input  logic             rx_pid_odd,
   input  logic             rx_err,
   output logic             hs_strobe,
   output logic [1:0]       hs_code,
   input  logic             fw_clr_toggle,
   input  logic             fw_flush,
   input  logic             fw_pkt_done,
   input  logic             fw_clr_sent_stall,
   input  logic             fw_clr_overrun,
   input  logic             rd_en,
   output logic [7:0]       rd_data,
   output logic             pkt_rdy,
   output logic             fifo_full,
   output logic             data_err,
   output logic             overrun,
   output logic             sent_stall,
   output logic [CNT_W-1:0] rx_count,
   output logic             irq
);
   if (MAX_PKT < 2 || (MAX_PKT & (MAX_PKT - 1)) != 0) begin : g_bad_max
      $error("MAX_PKT must be a power of two of at least 2");
   end

   logic open, wr_en, commit, stall_pulse, ovr_pulse, pop, last_rd, cur_err;
   logic [CNT_W-1:0] cur_len;
   hs_e  hs_q;

   oep_rx_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .iso(cfg_iso), .stall_req(cfg_stall),
      .clr_tog(fw_clr_toggle), .tok(tok_out), .vld(rx_vld), .eop(rx_eop),
      .pid_odd(rx_pid_odd), .rx_err(rx_err), .full(fifo_full),
      .open(open), .wr_en(wr_en), .commit(commit), .stall_pulse(stall_pulse),
      .ovr_pulse(ovr_pulse), .hs_strobe(hs_strobe), .hs_code(hs_q)
   );

   oep_pkt_store #(.MAX_PKT(MAX_PKT), .DBL_CAPABLE(DBL_CAPABLE)) u_store (
      .clk(clk), .rst_n(rst_n), .dbl(cfg_dbl), .open(open), .wr_en(wr_en),
      .wr_data(rx_byte), .commit(commit), .commit_err(rx_err), .pop(pop),
      .rd_en(rd_en), .full(fifo_full), .any(pkt_rdy), .rd_data(rd_data),
      .cur_len(cur_len), .cur_err(cur_err), .last_rd(last_rd)
   );

   assign hs_code  = hs_q;
   assign pop      = fw_pkt_done || fw_flush ||
                     (cfg_autoclr && last_rd && cur_len == cfg_max);
   assign rx_count = pkt_rdy ? cur_len : '0;
   assign data_err = pkt_rdy && cfg_iso && cur_err;
   assign irq      = irq_en && (pkt_rdy || sent_stall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sent_stall <= 1'b0;
         overrun    <= 1'b0;
      end else begin
         sent_stall <= stall_pulse || (sent_stall && !fw_clr_sent_stall);
         overrun    <= ovr_pulse   || (overrun && !fw_clr_overrun);
      end
   end

   // R10
   single_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_dbl && pkt_rdy) |-> fifo_full);
   // R8
   derr_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_err |-> (pkt_rdy && cfg_iso));
   // R7
   stall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall_pulse |=> sent_stall);
   // R12
   flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fw_flush && pkt_rdy && !cfg_dbl && !rx_eop) |=> !pkt_rdy);
endmodule

// File: tb/usb_out_ep_bench.sv
`timescale 1ns/1ps
module usb_out_ep_bench;
   localparam int MAXP = 64;
   localparam int CW   = $clog2(MAXP) + 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_iso = 0, cfg_dbl = 0, cfg_autoclr = 0, cfg_stall = 0, irq_en = 1;
   logic [CW-1:0] cfg_max = CW'(MAXP);
   logic tok_out = 0, rx_vld = 0, rx_eop = 0, rx_pid_odd = 0, rx_err = 0;
   logic [7:0] rx_byte = 0;
   logic hs_strobe;
   logic [1:0] hs_code;
   logic fw_clr_toggle = 0, fw_flush = 0, fw_pkt_done = 0;
   logic fw_clr_sent_stall = 0, fw_clr_overrun = 0, rd_en = 0;
   logic [7:0] rd_data;
   logic pkt_rdy, fifo_full, data_err, overrun, sent_stall, irq;
   logic [CW-1:0] rx_count;

   usb_out_ep #(.MAX_PKT(MAXP)) u_usb_out_ep (.*);

   always #2.5 clk = ~clk;

   int n_chk = 0, n_err = 0;
   // bench model of the slot ring
   bit m_tog = 0;
   int m_held = 0, m_rd = 0, m_wr = 0;
   int m_len [2];
   bit m_perr [2];
   logic [7:0] m_base [2];
   bit m_stall = 0, m_ovr = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int cap();
      return cfg_dbl ? 2 : 1;
   endfunction

   // expected handshake: -1 none, else code
   function automatic int exp_hs(input bit odd, input bit err);
      if (!cfg_iso && cfg_stall) return 3;
      if (cfg_iso || err) return -1;
      if (m_held >= cap()) return 2;
      return 1;
   endfunction

   task automatic send_pkt(input bit odd, input int n, input bit err, input string tag);
      bit got = 0;
      int code = 0, eh;
      logic [7:0] base = 8'($urandom);
      eh = exp_hs(odd, err);
      @(negedge clk); tok_out = 1;
      @(negedge clk); tok_out = 0;
      if (hs_strobe) begin got = 1; code = int'(hs_code); end
      for (int i = 0; i < n; i++) begin
         rx_vld = 1; rx_byte = base + 8'(i);
         @(negedge clk);
      end
      rx_vld = 0; rx_eop = 1; rx_pid_odd = odd; rx_err = err;
      @(negedge clk);
      rx_eop = 0; rx_err = 0;
      if (hs_strobe) begin got = 1; code = int'(hs_code); end
      chk(got == (eh >= 0) && (eh < 0 || code == eh), tag, got ? code : -1, eh);
      // model update
      if (!cfg_iso && cfg_stall) m_stall = 1;
      else if (m_held >= cap()) begin
         if (cfg_iso) m_ovr = 1;
      end else if (cfg_iso || (!err && odd == m_tog)) begin
         m_len[m_wr] = (n > MAXP) ? MAXP : n;
         m_perr[m_wr] = err;
         m_base[m_wr] = base;
         m_wr ^= 1; m_held++;
         if (!cfg_iso) m_tog = ~m_tog;
      end
   endtask

   task automatic check_current(input string tag);
      chk(pkt_rdy == (m_held > 0), tag, pkt_rdy, m_held > 0);
      if (m_held > 0) chk(int'(rx_count) == m_len[m_rd], tag, rx_count, m_len[m_rd]);
   endtask

   task automatic fw_read(input string tag);
      int bad = 0;
      bit autop;
      check_current(tag);
      chk(data_err == (cfg_iso && m_perr[m_rd]), {tag, " data_err"}, data_err,
          cfg_iso && m_perr[m_rd]);
      for (int i = 0; i < m_len[m_rd]; i++) begin
         if (rd_data != m_base[m_rd] + 8'(i)) bad++;
         rd_en = 1;
         @(negedge clk);
      end
      rd_en = 0;
      chk(bad == 0, {tag, " bytes"}, bad, 0);
      autop = cfg_autoclr && m_len[m_rd] == int'(cfg_max) && m_len[m_rd] > 0;
      if (!autop) begin
         fw_pkt_done = 1; @(negedge clk); fw_pkt_done = 0;
      end
      m_rd ^= 1; m_held--;
      check_current({tag, " after release"});
   endtask

   task automatic fw_do_flush(input string tag);
      fw_flush = 1; @(negedge clk); fw_flush = 0;
      if (m_held > 0) begin m_rd ^= 1; m_held--; end
      check_current(tag);
   endtask

   task automatic drain();
      while (m_held > 0) fw_read("drain R11");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!pkt_rdy && !fifo_full && !data_err && !overrun && !sent_stall && !irq && !hs_strobe,
          "R1 reset flags", {pkt_rdy, fifo_full, overrun, sent_stall, irq}, 0);
      rst_n = 1;
      @(negedge clk);
      // R2 good DATA0 packet, R14 irq
      send_pkt(0, 4, 0, "R2 ack DATA0");
      chk(irq == 1, "R14 irq on ready", irq, 1);
      chk(fifo_full == 1, "R10 single full", fifo_full, 1);
      fw_read("R2 read");
      chk(irq == 0, "R14 irq idle", irq, 0);
      // R3 retransmission of DATA0
      send_pkt(0, 3, 0, "R3 ack mismatch");
      chk(pkt_rdy == 0, "R3 mismatch discarded", pkt_rdy, 0);
      send_pkt(1, 5, 0, "R2 ack DATA1");
      fw_read("R2 read DATA1");
      // R4 clear toggle
      send_pkt(0, 2, 0, "R4 ack DATA0");
      fw_read("R4 read");
      fw_clr_toggle = 1; @(negedge clk); fw_clr_toggle = 0; m_tog = 0;
      send_pkt(1, 2, 0, "R4 DATA1 after clear");
      chk(pkt_rdy == 0, "R4 DATA1 discarded", pkt_rdy, 0);
      send_pkt(0, 2, 0, "R4 DATA0 after clear");
      fw_read("R4 read after clear");
      // R5 errored bulk packet
      send_pkt(1, 6, 1, "R5 no handshake");
      chk(pkt_rdy == 0, "R5 not stored", pkt_rdy, 0);
      // R6 NAK when full, toggle unchanged
      send_pkt(1, 7, 0, "R6 fill");
      send_pkt(0, 7, 0, "R6 nak");
      check_current("R6 dropped");
      fw_read("R6 read");
      send_pkt(0, 3, 0, "R6 toggle kept");
      fw_read("R6 read 2");
      // R10/R11/R12 double buffering
      cfg_dbl = 1;
      send_pkt(m_tog, 9, 0, "R10 dbl first");
      chk(fifo_full == 0, "R10 dbl one held", fifo_full, 0);
      send_pkt(m_tog, 12, 0, "R10 dbl second");
      chk(fifo_full == 1, "R10 dbl two held", fifo_full, 1);
      fw_do_flush("R12 first flush");
      chk(pkt_rdy == 1, "R12 one remains", pkt_rdy, 1);
      fw_do_flush("R12 second flush");
      send_pkt(m_tog, 1, 0, "R11 a");
      send_pkt(m_tog, 30, 0, "R11 b");
      fw_read("R11 first");
      fw_read("R11 second");
      // R7 stall
      cfg_stall = 1;
      send_pkt(m_tog, 4, 0, "R7 stall reply");
      chk(sent_stall == 1 && pkt_rdy == 0, "R7 sent_stall set", sent_stall, 1);
      chk(irq == 1, "R14 irq on stall", irq, 1);
      repeat (3) @(negedge clk);
      chk(sent_stall == 1, "R7 sent_stall holds", sent_stall, 1);
      fw_clr_sent_stall = 1; @(negedge clk); fw_clr_sent_stall = 0;
      chk(sent_stall == 0, "R7 sent_stall cleared", sent_stall, 0);
      // R7/R8 isochronous ignores stall, keeps errored packets
      cfg_iso = 1; cfg_dbl = 0;
      send_pkt(0, 5, 1, "R8 iso no handshake");
      chk(sent_stall == 0, "R7 iso not stalled", sent_stall, 0);
      chk(data_err == 1, "R8 data_err set", data_err, 1);
      // R9 overrun
      send_pkt(1, 5, 0, "R9 iso full");
      chk(overrun == 1, "R9 overrun set", overrun, 1);
      fw_read("R8 read iso");
      chk(data_err == 0, "R8 data_err cleared", data_err, 0);
      chk(overrun == 1, "R9 overrun holds", overrun, 1);
      fw_clr_overrun = 1; @(negedge clk); fw_clr_overrun = 0;
      chk(overrun == 0, "R9 overrun cleared", overrun, 0);
      cfg_stall = 0; cfg_iso = 0;
      // R13 auto-release
      cfg_autoclr = 1; cfg_max = CW'(8); cfg_dbl = 1;
      send_pkt(m_tog, 8, 0, "R13 max packet");
      send_pkt(m_tog, 5, 0, "R13 short packet");
      fw_read("R13 auto release");
      for (int i = 0; i < 5; i++) begin rd_en = 1; @(negedge clk); end
      rd_en = 0;
      chk(pkt_rdy == 1, "R13 short stays", pkt_rdy, 1);
      fw_pkt_done = 1; @(negedge clk); fw_pkt_done = 0;
      m_rd ^= 1; m_held--;
      check_current("R13 after done");
      cfg_autoclr = 0; cfg_max = CW'(MAXP);
      // random bulk traffic
      for (int ph = 0; ph < 2; ph++) begin
         drain();
         cfg_dbl = ph[0];
         for (int it = 0; it < 150; it++) begin
            int r = int'($urandom % 8);
            if (r < 4) begin
               bit odd = ($urandom % 4 == 0) ? ~m_tog : m_tog;
               send_pkt(odd, int'($urandom % 65), ($urandom % 10) == 0, "R2 R3 R6 random");
            end else if (r < 6) begin
               if (m_held > 0) fw_read("R11 random read");
            end else if (r == 6) begin
               if (m_held > 0) fw_do_flush("R12 random flush");
            end else begin
               fw_clr_toggle = 1; @(negedge clk); fw_clr_toggle = 0; m_tog = 0;
            end
            chk(fifo_full == (m_held >= cap()), "R10 random full", fifo_full, m_held >= cap());
         end
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule